// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

This block moves bytes between peripherals and memory without processor involvement. Four channels each keep a starting address and count that software programs through a byte-wide register port. Each channel also keeps a working address and a remaining count that advance after every byte. A peripheral raises its request line. The controller grants the highest-priority eligible channel and returns an acknowledge for one bus cycle. During that cycle it drives the working address together with a memory read or memory write strobe. The data itself passes directly between the peripheral and memory.

When the remaining count of a channel runs out, the controller flags end of process on the final byte. The channel then either reloads its starting values and waits for the next request, or masks itself until software writes it again. A separate copy mode moves a block from one memory region to another. Channel 0 supplies the source address and channel 1 supplies the destination address. Each byte goes through an internal holding register, so one byte takes a read cycle followed by a write cycle.

Top module: `dma4Ctrl`

## Requirements
- R1: After reset every channel is masked, so no request is granted until the channel is programmed. No acknowledge, strobe or end-of-process output is active.
- R2: Register map for `cpuAddr`:
  - Offset 2·c + 0 is the address register of channel c, and offset 2·c + 1 is its count register. Each is loaded as two byte writes, low byte first, steered by an internal byte pointer that toggles on each such write.
  - Offsets 8 to 11 hold the mode of channels 0 to 3. The mode fields are: bit 0 set means memory read and clear means memory write; bit 1 selects decrement; bit 2 selects auto-reload.
  - A write to offset 12 clears the byte pointer.
  - Bit 0 of a write to offset 13 enables copy mode.
- R3: A byte written to a channel's address or count register loads both the starting copy and the working copy, and unmasks that channel.
- R4: In a single transfer the acknowledge of the granted channel is high for exactly one cycle. In that cycle `memAddr` carries the working address and the strobe selected by mode bit 0 is high. The request is next sampled in the cycle after the acknowledge falls, so a held request is served every second cycle.
- R5: A count of N gives N transfers. The remaining count falls by one per transfer, and `eop` is high in the transfer cycle that takes the count from 1 to 0.
- R6: The working address steps by +1, or by −1 when mode bit 1 is set, after every transfer. It wraps within 16 bits (FFFF→0000 and 0000→FFFF).
- R7: After its final transfer, a channel without auto-reload stays masked while its request is held, until software writes its address or count.
- R8: With auto-reload set, the final transfer restores the starting address and count, so the next request repeats the block from the start.
- R9: Channels requesting in the same cycle are served in fixed priority order, channel 0 first and channel 3 last.
- R10: In copy mode a request on channel 0, with channels 0 and 1 unmasked, starts a copy. The copy alternates a read at channel 0's address with a write to channel 1's address on the next cycle. Each written byte is the byte read in the cycle before, and no acknowledge is given.
- R11: The copy ends on the write that takes channel 1's count from 1 to 0, with `eop` high on that write. Channels 0 and 1 then each reload or mask themselves according to their own auto-reload bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Register write strobe |
| cpuAddr | input | 4 | Register offset |
| cpuWdata | input | 8 | Register write data |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one-hot |
| memAddr | output | 16 | Memory address during a bus cycle |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memRdata | input | 8 | Memory read data (used in copy mode) |
| memWdata | output | 8 | Memory write data in copy mode |
| eop | output | 1 | End of process on the final byte |

## Verification
A request seen at a clock edge puts the transfer on the bus in the following cycle, because exactly one state register sits between them. A held request therefore produces bus cycles two cycles apart in single mode and one cycle apart in copy mode. The bench drives inputs on the falling edge and waits falling edge by falling edge for each bus cycle. It checks the number of cycles it waited against those spacings, and compares address, strobe, acknowledge, data and `eop` at that sample. Register writes take effect at the rising edge inside the write task, so each programming sequence is complete before the request that follows it is raised.

// File: rtl/dmaPkg.sv
`timescale 1ns/1ps
package dmaPkg;
  parameter int NUM_CH = 4;
  parameter int CH_W   = $clog2(NUM_CH);
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter int CPU_AW = CH_W + 2;

  typedef struct packed {
    logic autoInit;
    logic decr;
    logic memRead;
  } modeT;

  typedef struct packed {
    logic            step;
    logic [CH_W-1:0] ch;
    logic            keepCnt;
    logic            latchTemp;
    logic            tcCh0;
  } strobeT;
endpackage

// File: rtl/dmaDatapath.sv
`timescale 1ns/1ps
module dmaDatapath
  import dmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] curAddr [NUM_CH],
  output logic [NUM_CH-1:0] cntIsOne,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] memReadVec,
  output logic              m2mEn,
  output logic [DATA_W-1:0] tempByte
);
  logic [ADDR_W-1:0] baseAddr [NUM_CH];
  logic [ADDR_W-1:0] baseCnt  [NUM_CH];
  logic [ADDR_W-1:0] curCnt   [NUM_CH];
  logic [ADDR_W-1:0] stepAddr [NUM_CH];
  modeT              modeReg  [NUM_CH];
  logic              bytePtr;
  logic [CH_W-1:0]   regCh, modeCh, sCh;
  logic              isChanReg, isModeReg, regSel;
  logic              unusedWdata;

  assign regCh     = cpuAddr[CH_W:1];
  assign regSel    = cpuAddr[0];
  assign modeCh    = cpuAddr[CH_W-1:0];
  assign isChanReg = cpuWe && !cpuAddr[CPU_AW-1];
  assign isModeReg = cpuWe && cpuAddr[CPU_AW-1] && !cpuAddr[CH_W];
  assign sCh       = strobe.ch;
  assign unusedWdata = ^cpuWdata[DATA_W-1:3];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign stepAddr[g]   = modeReg[g].decr ? curAddr[g] - 1'b1 : curAddr[g] + 1'b1;
    assign cntIsOne[g]   = (curCnt[g] == ADDR_W'(1));
    assign memReadVec[g] = modeReg[g].memRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        baseAddr[i] <= '0;
        baseCnt[i]  <= '0;
        curAddr[i]  <= '0;
        curCnt[i]   <= '0;
        modeReg[i]  <= '0;
      end
      mask     <= '1;
      bytePtr  <= 1'b0;
      m2mEn    <= 1'b0;
      tempByte <= '0;
    end else begin
      if (isChanReg) begin
        if (!regSel) begin
          if (!bytePtr) begin
            baseAddr[regCh][DATA_W-1:0] <= cpuWdata;
            curAddr[regCh][DATA_W-1:0]  <= cpuWdata;
          end else begin
            baseAddr[regCh][ADDR_W-1:DATA_W] <= cpuWdata;
            curAddr[regCh][ADDR_W-1:DATA_W]  <= cpuWdata;
          end
        end else begin
          if (!bytePtr) begin
            baseCnt[regCh][DATA_W-1:0] <= cpuWdata;
            curCnt[regCh][DATA_W-1:0]  <= cpuWdata;
          end else begin
            baseCnt[regCh][ADDR_W-1:DATA_W] <= cpuWdata;
            curCnt[regCh][ADDR_W-1:DATA_W]  <= cpuWdata;
          end
        end
        mask[regCh] <= 1'b0;
        bytePtr     <= ~bytePtr;
      end else if (isModeReg) begin
        modeReg[modeCh] <= cpuWdata[2:0];
      end else if (cpuWe) begin
        if (!cpuAddr[0]) bytePtr <= 1'b0;
        else             m2mEn   <= cpuWdata[0];
      end

      if (strobe.step) begin
        if (strobe.keepCnt) begin
          curAddr[sCh] <= stepAddr[sCh];
        end else if (cntIsOne[sCh] && modeReg[sCh].autoInit) begin
          curAddr[sCh] <= baseAddr[sCh];
          curCnt[sCh]  <= baseCnt[sCh];
        end else begin
          curAddr[sCh] <= stepAddr[sCh];
          curCnt[sCh]  <= curCnt[sCh] - 1'b1;
          if (cntIsOne[sCh]) mask[sCh] <= 1'b1;
        end
      end

      if (strobe.tcCh0) begin
        if (modeReg[0].autoInit) begin
          curAddr[0] <= baseAddr[0];
          curCnt[0]  <= baseCnt[0];
        end else begin
          mask[0] <= 1'b1;
        end
      end

      if (strobe.latchTemp) tempByte <= memRdata;
    end
  end
endmodule

// File: rtl/dmaControl.sv
`timescale 1ns/1ps
module dmaControl
  import dmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] dreq,
  input  logic [NUM_CH-1:0] mask,
  input  logic [NUM_CH-1:0] cntIsOne,
  input  logic [NUM_CH-1:0] memReadVec,
  input  logic [ADDR_W-1:0] curAddr [NUM_CH],
  input  logic              m2mEn,
  input  logic [DATA_W-1:0] tempByte,
  output strobeT            strobe,
  output logic [NUM_CH-1:0] dack,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic              eop
);
  typedef enum logic [1:0] {S_IDLE, S_SGL, S_MRD, S_MWR} stateT;

  stateT           state, stateNext;
  logic [CH_W-1:0] curCh, chNext, winner;
  logic [NUM_CH-1:0] eligible;
  logic            anyReq, m2mGo;

  assign m2mGo = m2mEn && dreq[0] && !mask[0] && !mask[1];

  always_comb begin
    eligible = dreq & ~mask;
    if (m2mEn) eligible[0] = 1'b0;
  end

  always_comb begin
    winner = '0;
    anyReq = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        winner = CH_W'(i);
        anyReq = 1'b1;
      end
    end
  end

  always_comb begin
    stateNext = state;
    chNext    = curCh;
    case (state)
      S_IDLE: begin
        if (m2mGo) stateNext = S_MRD;
        else if (anyReq) begin
          stateNext = S_SGL;
          chNext    = winner;
        end
      end
      S_SGL:   stateNext = S_IDLE;
      S_MRD:   stateNext = S_MWR;
      S_MWR:   stateNext = cntIsOne[1] ? S_IDLE : S_MRD;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      curCh <= '0;
    end else begin
      state <= stateNext;
      curCh <= chNext;
    end
  end

  assign memWdata = tempByte;

  always_comb begin
    strobe  = '0;
    dack    = '0;
    memAddr = '0;
    memRd   = 1'b0;
    memWr   = 1'b0;
    eop     = 1'b0;
    case (state)
      S_SGL: begin
        dack[curCh] = 1'b1;
        memAddr     = curAddr[curCh];
        memRd       = memReadVec[curCh];
        memWr       = !memReadVec[curCh];
        eop         = cntIsOne[curCh];
        strobe.step = 1'b1;
        strobe.ch   = curCh;
      end
      S_MRD: begin
        memAddr          = curAddr[0];
        memRd            = 1'b1;
        strobe.step      = 1'b1;
        strobe.ch        = '0;
        strobe.keepCnt   = 1'b1;
        strobe.latchTemp = 1'b1;
      end
      S_MWR: begin
        memAddr      = curAddr[1];
        memWr        = 1'b1;
        eop          = cntIsOne[1];
        strobe.step  = 1'b1;
        strobe.ch    = CH_W'(1);
        strobe.tcCh0 = cntIsOne[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dma4Ctrl.sv
`timescale 1ns/1ps
module dma4Ctrl
  import dmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWe,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dack,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic              eop
);
  strobeT            strobe;
  logic [ADDR_W-1:0] curAddr [NUM_CH];
  logic [NUM_CH-1:0] cntIsOne, mask, memReadVec;
  logic              m2mEn;
  logic [DATA_W-1:0] tempByte;

  dmaDatapath uDp (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .strobe(strobe), .memRdata(memRdata), .curAddr(curAddr), .cntIsOne(cntIsOne),
    .mask(mask), .memReadVec(memReadVec), .m2mEn(m2mEn), .tempByte(tempByte)
  );

  dmaControl uCtl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .mask(mask), .cntIsOne(cntIsOne),
    .memReadVec(memReadVec), .curAddr(curAddr), .m2mEn(m2mEn), .tempByte(tempByte),
    .strobe(strobe), .dack(dack), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .eop(eop)
  );
endmodule

// File: rtl/dmaChecker.sv
`timescale 1ns/1ps
module dmaChecker
  import dmaPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] dack,
  input logic              memRd,
  input logic              memWr,
  input logic [DATA_W-1:0] memRdata,
  input logic [DATA_W-1:0] memWdata,
  input logic              eop
);
  // R9
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(dack));

  // R4
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(memRd && memWr));

  // R4
  dack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dack != '0) |=> (dack == '0));

  // R5
  eop_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    eop |-> (memRd || memWr));

  // R10
  m2m_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && dack == '0) |=> (memWr && dack == '0));

  // R10
  m2m_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && dack == '0) |-> (memWdata == $past(memRdata)));
endmodule

bind dma4Ctrl dmaChecker uChk (
  .clk(clk), .rstN(rstN), .dack(dack), .memRd(memRd), .memWr(memWr),
  .memRdata(memRdata), .memWdata(memWdata), .eop(eop)
);

// File: tb/sim_dma4Ctrl.sv
`timescale 1ns/1ps
module sim_dma4Ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [3:0]  cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [15:0] memAddr;
  logic        memRd, memWr, eop;
  logic [7:0]  memRdata, memWdata;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign memRdata = memFn(memAddr);

  dma4Ctrl u0 (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .dreq(dreq), .dack(dack), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memRdata(memRdata), .memWdata(memWdata), .eop(eop)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] n, input logic [2:0] m);
    cpuWr(4'd12, 8'h00);
    cpuWr(4'(2*ch), a[7:0]);
    cpuWr(4'(2*ch), a[15:8]);
    cpuWr(4'(2*ch+1), n[7:0]);
    cpuWr(4'(2*ch+1), n[15:8]);
    cpuWr(4'(8+ch), {5'd0, m});
  endtask

  task automatic expectXfer(input string req, input logic [3:0] eDack, input logic [15:0] eAddr,
                            input logic eRd, input logic eEop, input int eGap);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(memRd || memWr) && n < 30);
    check(memRd || memWr, {req, " bus cycle"}, 32'(memRd || memWr), 32'd1);
    check(dack == eDack, {req, " dack"}, 32'(dack), 32'(eDack));
    check(memAddr == eAddr, {req, " addr"}, 32'(memAddr), 32'(eAddr));
    check(memRd == eRd && memWr == !eRd, {req, " strobe"}, {30'd0, memRd, memWr}, {30'd0, eRd, !eRd});
    check(eop == eEop, {req, " eop"}, 32'(eop), 32'(eEop));
    if (eGap > 0) check(n == eGap, {req, " spacing"}, 32'(n), 32'(eGap));
  endtask

  task automatic expectQuiet(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!(memRd || memWr) && dack == '0, req, {27'd0, dack, memRd}, 32'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dack == '0 && !memRd && !memWr && !eop, "R1 outputs in reset",
          {27'd0, dack, memRd}, 32'd0);
    rstN = 1'b1;
    dreq = 4'hF;
    expectQuiet("R1 masked after reset", 5);
    dreq = '0;

    // R2 byte pointer clear, R3 base loads working copy, R4 spacing, R5 count
    cpuWr(4'd4, 8'hAA);
    cpuWr(4'd12, 8'h00);
    cpuWr(4'd4, 8'h30);
    cpuWr(4'd4, 8'h12);
    cpuWr(4'd5, 8'h03);
    cpuWr(4'd5, 8'h00);
    cpuWr(4'd10, 8'h01);
    dreq = 4'b0100;
    expectXfer("R2 R3 ch2 first", 4'b0100, 16'h1230, 1'b1, 1'b0, 0);
    expectXfer("R4 ch2 second", 4'b0100, 16'h1231, 1'b1, 1'b0, 2);
    expectXfer("R5 ch2 last", 4'b0100, 16'h1232, 1'b1, 1'b1, 2);
    // R7 stays masked while request held
    expectQuiet("R7 masked after final", 6);
    dreq = '0;
    // R3 rewrite of count unmasks; R6 address kept stepping
    cpuWr(4'd12, 8'h00);
    cpuWr(4'd5, 8'h01);
    cpuWr(4'd5, 8'h00);
    dreq = 4'b0100;
    expectXfer("R3 R6 ch2 rewritten count", 4'b0100, 16'h1233, 1'b1, 1'b1, 0);
    dreq = '0;

    // R6 decrement with wrap, R8 auto-reload, memory write
    prog(3, 16'h0001, 16'd3, 3'b110);
    dreq = 4'b1000;
    expectXfer("R6 ch3 dec 1", 4'b1000, 16'h0001, 1'b0, 1'b0, 0);
    expectXfer("R6 ch3 dec 2", 4'b1000, 16'h0000, 1'b0, 1'b0, 2);
    expectXfer("R6 ch3 dec wrap", 4'b1000, 16'hFFFF, 1'b0, 1'b1, 2);
    expectXfer("R8 ch3 reload", 4'b1000, 16'h0001, 1'b0, 1'b0, 2);
    expectXfer("R8 ch3 reload next", 4'b1000, 16'h0000, 1'b0, 1'b0, 2);
    dreq = '0;

    // R6 increment wrap
    prog(1, 16'hFFFF, 16'd2, 3'b001);
    dreq = 4'b0010;
    expectXfer("R6 ch1 inc top", 4'b0010, 16'hFFFF, 1'b1, 1'b0, 0);
    expectXfer("R6 ch1 inc wrap", 4'b0010, 16'h0000, 1'b1, 1'b1, 2);
    dreq = '0;

    // R9 priority ch1 over ch2
    prog(1, 16'h0400, 16'd2, 3'b001);
    prog(2, 16'h0500, 16'd2, 3'b000);
    dreq = 4'b0110;
    expectXfer("R9 ch1 a", 4'b0010, 16'h0400, 1'b1, 1'b0, 0);
    expectXfer("R9 ch1 b", 4'b0010, 16'h0401, 1'b1, 1'b1, 2);
    expectXfer("R9 ch2 a", 4'b0100, 16'h0500, 1'b0, 1'b0, 2);
    expectXfer("R9 ch2 b", 4'b0100, 16'h0501, 1'b0, 1'b1, 2);
    dreq = '0;
    // R9 ch0 over ch3 (ch3 holds address FFFF, one byte left)
    prog(0, 16'h0600, 16'd1, 3'b001);
    dreq = 4'b1001;
    expectXfer("R9 ch0 first", 4'b0001, 16'h0600, 1'b1, 1'b1, 0);
    expectXfer("R9 ch3 after", 4'b1000, 16'hFFFF, 1'b0, 1'b1, 2);
    dreq = '0;

    // R10 R11 copy, no auto-reload
    cpuWr(4'd13, 8'h01);
    prog(0, 16'h0100, 16'd1, 3'b000);
    prog(1, 16'h0200, 16'd3, 3'b000);
    dreq = 4'b0001;
    expectXfer("R10 read 0", 4'b0000, 16'h0100, 1'b1, 1'b0, 0);
    dreq = '0;
    for (int k = 0; k < 3; k++) begin
      expectXfer("R10 write", 4'b0000, 16'(16'h0200 + k), 1'b0, (k == 2), 1);
      check(memWdata == memFn(16'(16'h0100 + k)), "R10 copied byte", 32'(memWdata),
            32'(memFn(16'(16'h0100 + k))));
      if (k < 2) expectXfer("R10 read", 4'b0000, 16'(16'h0101 + k), 1'b1, 1'b0, 1);
    end
    dreq = 4'b0001;
    expectQuiet("R11 both masked after copy", 6);
    dreq = '0;

    // R11 copy with auto-reload on both channels
    prog(0, 16'h0110, 16'd1, 3'b100);
    prog(1, 16'h0300, 16'd2, 3'b100);
    dreq = 4'b0001;
    expectXfer("R11 read a", 4'b0000, 16'h0110, 1'b1, 1'b0, 0);
    dreq = '0;
    expectXfer("R11 write a", 4'b0000, 16'h0300, 1'b0, 1'b0, 1);
    expectXfer("R11 read b", 4'b0000, 16'h0111, 1'b1, 1'b0, 1);
    expectXfer("R11 write b", 4'b0000, 16'h0301, 1'b0, 1'b1, 1);
    dreq = 4'b0001;
    expectXfer("R11 reload read", 4'b0000, 16'h0110, 1'b1, 1'b0, 0);
    dreq = '0;
    expectXfer("R11 reload write", 4'b0000, 16'h0300, 1'b0, 1'b0, 1);
    check(memWdata == memFn(16'h0110), "R11 reload data", 32'(memWdata), 32'(memFn(16'h0110)));
    expectXfer("R11 reload read b", 4'b0000, 16'h0111, 1'b1, 1'b0, 1);
    expectXfer("R11 reload write b", 4'b0000, 16'h0301, 1'b0, 1'b1, 1);
    cpuWr(4'd13, 8'h00);
    expectQuiet("R10 idle after copy off", 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule